// File: doc/BRIEF.md
# PWM Time-Base Counter with Synchronization Chain

This block is the timing heart of one pulse-width modulation channel. A 16-bit counter advances on ticks produced by a power-of-two prescaler of the system clock. It counts up, counts down, or counts up and then down against a programmable period. It raises level events when the count sits at zero, at the period, or at a compare-B value. It also reports the counting direction and keeps a sticky flag that shows the count has reached its all-ones value.

Channels can be daisy-chained. Each channel takes a synchronization pulse from the channel before it. When it is allowed to, it uses that pulse to jump its count to a programmed phase value. It forwards a pulse to the next channel, taken from the incoming pulse, from its own zero event or from its own compare-B event. Software reaches the block through a simple write-only register port.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the period is 0, the mode is up-count, sync is disabled, the prescale exponent is 0 and the sync-out source is pass-through. The max flag is 0, the direction output is 1, and the zero and period events are both 1.
- R2: In up-count mode (mode code 0), on each tick the count goes to 0 if it equals or exceeds the period, and otherwise it increases by 1. The direction output is 1 in this mode.
- R3: In down-count mode (mode code 1), on each tick the count reloads the period if it is 0, and otherwise it decreases by 1. The direction output is 0 in this mode.
- R4: In up-down mode (mode code 2), the count rises from 0 to the period and then falls back to 0, repeating. The direction output is 1 from the tick that leaves 0 until the tick that leaves the period, and 0 while falling and at the bottom.
- R5: evt_zero is high exactly when the count is 0, evt_period exactly when the count equals the period, and evt_cmpb exactly when the count equals compare-B.
- R6: With prescale exponent N (control bits 5:3), a tick occurs once every 2^N system clocks. The count changes only on ticks, apart from register writes to the count.
- R7: With sync enabled (control bit 2), a sync_in pulse makes the next tick (the tick in the same cycle, if there is one) load the phase register instead of counting. In up-down mode that tick also loads the direction from control bit 8 (1 = up).
- R8: With sync disabled, sync_in has no effect on the count.
- R9: sync_out follows control bits 7:6. Code 0 passes sync_in through combinationally. Code 1 gives tick AND zero event. Code 2 gives tick AND compare-B event. Code 3 holds sync_out at 0.
- R10: max_flag sets in the cycle after the count equals FFFFh and stays set until a write of 1 to bit 0 of the status address. Writing 0 there leaves it set. The flag never alters counting.
- R11: Writes take effect at the clock edge that samples wr_en. The addresses are: 0 control, 1 period, 2 compare-B, 3 phase, 4 status, 5 count. A count write overrides that cycle's tick. Mode code 3 freezes the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| sync_in | input | 1 | Sync pulse from the previous channel |
| sync_out | output | 1 | Sync pulse to the next channel |
| cnt_value | output | 16 | Current count |
| cnt_dir | output | 1 | 1 while counting up, 0 while counting down |
| evt_zero | output | 1 | Count equals zero |
| evt_period | output | 1 | Count equals period |
| evt_cmpb | output | 1 | Count equals compare-B |
| max_flag | output | 1 | Sticky flag: count reached all ones |

## Verification
Several properties about what happens at the period or zero boundary assume the mode does not change in that cycle. They therefore exclude any cycle with wr_en high. They also assume no sync load is pending. The stimulus changes configuration only in hold mode, or checks mid-run writes only through port values. Sync pulses are one cycle wide and come only in runs that check their effect. The sweeps use a prescale of 1 so that every cycle is a tick, and the expected count is computed as a modulo function of the tick number.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

    typedef enum logic [1:0] {
        MODE_UP   = 2'd0,
        MODE_DOWN = 2'd1,
        MODE_UPDN = 2'd2,
        MODE_HOLD = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        SO_PASS = 2'd0,
        SO_ZERO = 2'd1,
        SO_CMPB = 2'd2,
        SO_OFF  = 2'd3
    } so_sel_e;

    // packed: phase_up is bit 8, mode is bits 1:0
    typedef struct packed {
        logic      phase_up;
        so_sel_e   so_sel;
        logic [2:0] psc;
        logic      sync_en;
        cnt_mode_e mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_PERIOD = 3'd1;
    localparam logic [2:0] ADDR_CMPB   = 3'd2;
    localparam logic [2:0] ADDR_PHASE  = 3'd3;
    localparam logic [2:0] ADDR_STATUS = 3'd4;
    localparam logic [2:0] ADDR_COUNT  = 3'd5;

endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int DIV_W = (2 ** PSC_W) - 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = DIV_W'((32'd1 << psc) - 32'd1);
        tick  = (div_q >= limit);
        div_d = tick ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] period,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_up,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_up
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cnt) begin
            st_d.cnt = wr_val;
        end else if (tick) begin
            if (load) begin
                st_d.cnt = load_val;
                if (mode == MODE_UPDN) st_d.dir = load_up;
            end else begin
                unique case (mode)
                    MODE_UP: begin
                        st_d.cnt = (st_q.cnt >= period) ? '0 : st_q.cnt + 1'b1;
                    end
                    MODE_DOWN: begin
                        st_d.cnt = (st_q.cnt == '0) ? period : st_q.cnt - 1'b1;
                    end
                    MODE_UPDN: begin
                        if (st_q.dir) begin
                            if (st_q.cnt >= period) begin
                                st_d.dir = 1'b0;
                                st_d.cnt = (st_q.cnt == '0) ? '0 : st_q.cnt - 1'b1;
                            end else begin
                                st_d.cnt = st_q.cnt + 1'b1;
                            end
                        end else begin
                            if (st_q.cnt == '0) begin
                                st_d.dir = 1'b1;
                                st_d.cnt = (period == '0) ? '0 : CNT_W'(1);
                            end else begin
                                st_d.cnt = st_q.cnt - 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.dir <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cnt = st_q.cnt;
        unique case (mode)
            MODE_UP:   dir_up = 1'b1;
            MODE_DOWN: dir_up = 1'b0;
            default:   dir_up = st_q.dir;
        endcase
    end
endmodule

// File: rtl/pwm_tb_sync.sv
module pwm_tb_sync
    import pwm_tb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    sync_in,
    input  logic    sync_en,
    input  so_sel_e so_sel,
    input  logic    evt_zero,
    input  logic    evt_cmpb,
    output logic    load,
    output logic    sync_out
);
    logic pend_d, pend_q;
    logic req;

    always_comb begin
        req    = sync_en & (pend_q | sync_in);
        load   = tick & req;
        pend_d = req & ~tick;
        unique case (so_sel)
            SO_PASS: sync_out = sync_in;
            SO_ZERO: sync_out = tick & evt_zero;
            SO_CMPB: sync_out = tick & evt_cmpb;
            default: sync_out = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             sync_in,
    output logic             sync_out,
    output logic [CNT_W-1:0] cnt_value,
    output logic             cnt_dir,
    output logic             evt_zero,
    output logic             evt_period,
    output logic             evt_cmpb,
    output logic             max_flag
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] cmpb;
        logic [CNT_W-1:0] phase;
        logic             max;
    } regs_t;

    regs_t rg_d, rg_q;

    logic             tick;
    logic             sync_load;
    logic             wr_cnt;
    cnt_mode_e        ctl_mode;
    logic             ctl_sync_en;
    logic [CNT_W-1:0] ctl_period;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        rg_d   = rg_q;
        wr_cnt = wr_en && (wr_addr == ADDR_COUNT);
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL:   rg_d.ctrl   = ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_PERIOD: rg_d.period = wr_data;
                ADDR_CMPB:   rg_d.cmpb   = wr_data;
                ADDR_PHASE:  rg_d.phase  = wr_data;
                ADDR_STATUS: if (wr_data[0]) rg_d.max = 1'b0;
                default: ;
            endcase
        end
        if (cnt == '1) rg_d.max = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign ctl_mode    = rg_q.ctrl.mode;
    assign ctl_sync_en = rg_q.ctrl.sync_en;
    assign ctl_period  = rg_q.period;

    pwm_tb_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .psc   (PSC_W'(rg_q.ctrl.psc)),
        .tick  (tick)
    );

    pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (ctl_mode),
        .period   (ctl_period),
        .load     (sync_load),
        .load_val (rg_q.phase),
        .load_up  (rg_q.ctrl.phase_up),
        .wr_cnt   (wr_cnt),
        .wr_val   (wr_data),
        .cnt      (cnt),
        .dir_up   (cnt_dir)
    );

    assign evt_zero   = (cnt == '0);
    assign evt_period = (cnt == rg_q.period);
    assign evt_cmpb   = (cnt == rg_q.cmpb);

    pwm_tb_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sync_in  (sync_in),
        .sync_en  (ctl_sync_en),
        .so_sel   (rg_q.ctrl.so_sel),
        .evt_zero (evt_zero),
        .evt_cmpb (evt_cmpb),
        .load     (sync_load),
        .sync_out (sync_out)
    );

    assign cnt_value = cnt;
    assign max_flag  = rg_q.max;
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             load,
    input logic             wr_en,
    input cnt_mode_e        mode,
    input logic             sync_en,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] cnt,
    input logic             dir,
    input logic             max_flag,
    input logic             sync_out,
    input so_sel_e          so_sel
);
    // R6
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(cnt));

    // R2
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && !load && mode == MODE_UP && cnt >= period) |=> (cnt == '0));

    // R3
    down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && !load && mode == MODE_DOWN && cnt == '0) |=> (cnt == $past(period)));

    // R4
    dir_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UP |-> dir) and (mode == MODE_DOWN |-> !dir));

    // R8
    sync_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_en && tick && !wr_en && mode == MODE_UP && cnt < period)
        |=> (cnt == $past(cnt) + 1'b1));

    // R9
    so_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (so_sel == SO_OFF) |-> !sync_out);

    // R10
    max_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1) |=> max_flag);
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (sync_load),
    .wr_en    (wr_en),
    .mode     (ctl_mode),
    .sync_en  (ctl_sync_en),
    .period   (ctl_period),
    .cnt      (cnt_value),
    .dir      (cnt_dir),
    .max_flag (max_flag),
    .sync_out (sync_out),
    .so_sel   (rg_q.ctrl.so_sel)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
    localparam int CLK_PERIOD = 10;
    localparam int CB = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sync_in = 1'b0;
    logic        sync_out;
    logic [15:0] cnt_value;
    logic        cnt_dir, evt_zero, evt_period, evt_cmpb, max_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_timebase dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_in(sync_in), .sync_out(sync_out),
        .cnt_value(cnt_value), .cnt_dir(cnt_dir), .evt_zero(evt_zero),
        .evt_period(evt_period), .evt_cmpb(evt_cmpb), .max_flag(max_flag)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // control word: phase_up[8] so_sel[7:6] psc[5:3] sync_en[2] mode[1:0]
    function automatic logic [15:0] ctl(int mode, int sen, int psc, int sel, int pup);
        return 16'((pup << 8) | (sel << 6) | (psc << 3) | (sen << 2) | mode);
    endfunction

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic next_cyc();
        @(negedge clk);
    endtask

    function automatic int exp_cnt(int mode, int p, int k);
        int m;
        if (mode == 0) return k % (p + 1);
        if (mode == 1) return p - (k % (p + 1));
        m = k % (2 * p);
        return (m <= p) ? m : 2 * p - m;
    endfunction

    task automatic run_case(int mode, int p, int sel);
        int e, m;
        logic [15:0] c = ctl(mode, 0, 0, sel, 1);
        wr(0, ctl(3, 0, 0, sel, 1));
        wr(1, 16'(p));
        wr(2, 16'(CB));
        wr(5, (mode == 1) ? 16'(p) : 16'd0);
        wr(0, c);
        for (int k = 0; k <= 3 * (p + 1) + 2; k++) begin
            if (k > 0) next_cyc();
            e = exp_cnt(mode, p, k);
            if (mode == 0) check("R2 count", cnt_value, e);
            else if (mode == 1) check("R3 count", cnt_value, e);
            else check("R4 count", cnt_value, e);
            if (mode == 0) check("R2 dir", cnt_dir, 1);
            if (mode == 1) check("R3 dir", cnt_dir, 0);
            if (mode == 2 && k > 0) begin
                m = k % (2 * p);
                check("R4 dir", cnt_dir, (m >= 1 && m <= p) ? 1 : 0);
            end
            check("R5 zero", evt_zero, (e == 0) ? 1 : 0);
            check("R5 period", evt_period, (e == p) ? 1 : 0);
            check("R5 cmpb", evt_cmpb, (e == CB) ? 1 : 0);
            if (sel == 1) check("R9 zero src", sync_out, (e == 0) ? 1 : 0);
            if (sel == 2) check("R9 cmpb src", sync_out, (e == CB) ? 1 : 0);
            if (sel == 3) check("R9 off", sync_out, 0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        next_cyc();
        // R1 reset state
        check("R1 count", cnt_value, 0);
        check("R1 max", max_flag, 0);
        check("R1 dir", cnt_dir, 1);
        check("R1 zero", evt_zero, 1);
        check("R1 period", evt_period, 1);
        next_cyc();
        check("R1 count held with period 0", cnt_value, 0);
        check("R1 sync pass", sync_out, 0);

        // R2 R3 R4 R5 R9 sweeps
        for (int p = 0; p <= 6; p++) run_case(0, p, 1 + (p % 3));
        for (int p = 0; p <= 6; p++) run_case(1, p, 1 + ((p + 1) % 3));
        for (int p = 1; p <= 6; p++) run_case(2, p, 1 + ((p + 2) % 3));

        // R11 hold mode and count write
        wr(0, ctl(3, 0, 0, 0, 1));
        wr(5, 16'h1234);
        check("R11 count write", cnt_value, 16'h1234);
        repeat (5) next_cyc();
        check("R11 hold", cnt_value, 16'h1234);

        // R6 prescaler
        wr(1, 16'd1000);
        wr(5, 16'd0);
        wr(0, ctl(0, 0, 2, 0, 1));
        next_cyc();
        c0 = cnt_value;
        repeat (4) next_cyc();
        check("R6 div4 one tick", cnt_value, c0 + 1);
        repeat (40) next_cyc();
        check("R6 div4 ten ticks", cnt_value, c0 + 11);
        wr(0, ctl(0, 0, 7, 0, 1));
        next_cyc();
        c0 = cnt_value;
        repeat (128) next_cyc();
        check("R6 div128", cnt_value, c0 + 1);
        repeat (256) next_cyc();
        check("R6 div128 two more", cnt_value, c0 + 3);

        // R7 sync load in up mode, N=0
        wr(0, ctl(3, 1, 0, 0, 1));
        wr(1, 16'd20);
        wr(3, 16'd7);
        wr(5, 16'd0);
        wr(0, ctl(0, 1, 0, 0, 1));
        repeat (3) next_cyc();
        check("R7 pre count", cnt_value, 3);
        sync_in = 1'b1;
        #1;
        check("R9 pass src", sync_out, 1);
        next_cyc();
        sync_in = 1'b0;
        check("R7 phase load", cnt_value, 7);
        next_cyc();
        check("R7 after load", cnt_value, 8);

        // R8 sync disabled
        wr(0, ctl(0, 0, 0, 0, 1));
        c0 = cnt_value;
        sync_in = 1'b1;
        next_cyc();
        sync_in = 1'b0;
        check("R8 ignored", cnt_value, c0 + 1);
        next_cyc();
        check("R8 ignored next", cnt_value, c0 + 2);

        // R7 up-down load with direction bit 0
        wr(0, ctl(2, 1, 0, 0, 0));
        sync_in = 1'b1;
        next_cyc();
        sync_in = 1'b0;
        check("R7 updn phase", cnt_value, 7);
        check("R7 updn dir", cnt_dir, 0);
        next_cyc();
        check("R7 updn falls", cnt_value, 6);

        // R7 R6 pending sync with prescale
        wr(0, ctl(0, 1, 2, 0, 1));
        sync_in = 1'b1;
        next_cyc();
        sync_in = 1'b0;
        repeat (3) next_cyc();
        check("R7 pending load", cnt_value, 7);

        // R10 max flag
        wr(0, ctl(3, 0, 0, 0, 1));
        wr(1, 16'hFFFF);
        wr(5, 16'hFFFE);
        wr(0, ctl(0, 0, 0, 0, 1));
        check("R10 pre", max_flag, 0);
        next_cyc();
        check("R10 count max", cnt_value, 16'hFFFF);
        check("R10 not yet", max_flag, 0);
        next_cyc();
        check("R10 set", max_flag, 1);
        check("R10 wrap", cnt_value, 0);
        next_cyc();
        check("R10 counting on", cnt_value, 1);
        wr(4, 16'h0000);
        check("R10 write 0 keeps", max_flag, 1);
        wr(4, 16'h0001);
        check("R10 clear", max_flag, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule